// File: doc/BRIEF.md
# Bit-Band Alias Bus Translator

This block sits between a 32-bit bus master and a word-addressed downstream bus. It checks each upstream request against two alias windows, each 32 MB wide. In these windows every word address stands for one bit of a 1 MB target region. An alias read fetches the target word and returns only the selected bit. An alias write reads the target word, replaces the one bit and writes the word back. The downstream lock output stays high throughout this sequence, so no other master can modify the word between the read and the write.

All other requests go downstream unchanged, after one register stage. Both sides use valid/ready request handshakes. Only one transaction is in flight at a time, and the upstream port stays stalled until the response for the current transaction has been returned. Every downstream request, write or read, gets exactly one response pulse.

Top module: `bitband_xlate`

## Requirements
- R1: Requests with address bits [31:25] equal to 0x11 (window 0x2200_0000..0x23FF_FFFF) target region base 0x2000_0000. Requests with bits [31:25] equal to 0x21 (window 0x4200_0000..0x43FF_FFFF) target region base 0x4000_0000. The target word address is the region base plus (addr[24:7] << 2). The bit position is addr[6:2]. Address bits [1:0] of an alias request are ignored.
- R2: An alias read issues exactly one downstream read of the target word with dnLock low. Its response data is 32'h0000_000X, where X is the selected bit of the returned word.
- R3: An alias write issues a downstream read of the target word, then a write to the same address with all four strobes set. The write data equals the word that was read, with the selected bit replaced by bit 0 of the upstream write data. The upstream strobes and write-data bits [31:1] are ignored. The upstream response data is zero.
- R4: dnLock is high from the cycle the alias-write read request is first presented until the cycle in which the response to the write arrives. It is low in all other cycles, and both transfers of the read-modify-write are made with dnLock high.
- R5: A request outside both windows is forwarded downstream with its address, write flag, write data and strobes unchanged, and with dnLock low. The upstream response data equals dnRdata.
- R6: The downstream request is presented in the cycle after upstream acceptance. upRspValid rises in the cycle after the final dnRspValid. With zero downstream wait states, a response is due 2 clock edges after acceptance, or 4 edges for an alias write. Each downstream wait cycle adds one edge per transfer.
- R7: upReady is low from the cycle after acceptance until the response cycle has ended.
- R8: While dnValid is high and dnReady is low, dnValid stays high and dnAddr, dnWrite and dnWdata hold their values.
- R9: After reset, upReady is 1, and dnValid, dnLock and upRspValid are 0.
- R10: upRspValid is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| upValid | input | 1 | Upstream request valid |
| upReady | output | 1 | Upstream request accepted when high together with upValid |
| upAddr | input | 32 | Upstream byte address |
| upWrite | input | 1 | Upstream request is a write |
| upWdata | input | 32 | Upstream write data |
| upStrb | input | 4 | Upstream byte write strobes |
| upRspValid | output | 1 | Upstream response pulse |
| upRdata | output | 32 | Upstream response data |
| dnValid | output | 1 | Downstream request valid |
| dnReady | input | 1 | Downstream request accepted |
| dnAddr | output | 32 | Downstream word address |
| dnWrite | output | 1 | Downstream request is a write |
| dnWdata | output | 32 | Downstream write data |
| dnStrb | output | 4 | Downstream byte write strobes |
| dnLock | output | 1 | Bus lock during an alias read-modify-write |
| dnRspValid | input | 1 | Downstream response pulse |
| dnRdata | input | 32 | Downstream response data |

## Verification
The bench counts clock edges from upstream acceptance to the upRspValid pulse. It compares that count with 2 edges for a forwarded request or alias read, and 4 for an alias write, plus one edge for every wait cycle its downstream responder inserts on each transfer. During that window it samples upReady one time unit after each edge. Every downstream handshake is logged at the edge where it happens, with its address, data, strobes and lock. The log is compared with the transfers that a behavioural address model and a shadow memory predict. Read-back through forwarded reads confirms that an alias write changed only the selected bit.

// File: rtl/bbx_pkg.sv
package bbx_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int BIT_W  = $clog2(DATA_W);
  localparam int NUM_REGIONS = 2;

  localparam logic [NUM_REGIONS-1:0][31:0] DEF_REGION_BASE = {32'h4000_0000, 32'h2000_0000};
  localparam logic [NUM_REGIONS-1:0][31:0] DEF_ALIAS_BASE  = {32'h4200_0000, 32'h2200_0000};

  typedef enum logic [1:0] {PH_PASS, PH_ALRD, PH_ALWR} phase_e;
  typedef enum logic [1:0] {RSP_RAW, RSP_BIT, RSP_ZERO} rspSel_e;

  typedef struct packed {
    logic    capReq;
    logic    capWord;
    logic    capRsp;
    rspSel_e rspSel;
    phase_e  phase;
  } dpStrobe_t;
endpackage

// File: rtl/bbx_alias_decode.sv
module bbx_alias_decode
  import bbx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 20,
  parameter logic [NUM_REGIONS-1:0][31:0] REGION_BASE = DEF_REGION_BASE,
  parameter logic [NUM_REGIONS-1:0][31:0] ALIAS_BASE  = DEF_ALIAS_BASE
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [ADDR_W-1:0] wordAddr,
  output logic [BIT_W-1:0]  bitPos
);
  // one alias word per bit: 8 bits per byte, 4 address bytes per alias word
  localparam int ALIAS_BITS = REGION_BITS + 3 + 2;
  localparam int PAD_W      = ADDR_W - REGION_BITS;

  logic [NUM_REGIONS-1:0] regHit;
  logic [ADDR_W-1:0]      regAddr [NUM_REGIONS];

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    assign regHit[i]  = (addr[ADDR_W-1:ALIAS_BITS] == ALIAS_BASE[i][ADDR_W-1:ALIAS_BITS]);
    assign regAddr[i] = regHit[i]
      ? (REGION_BASE[i][ADDR_W-1:0] | {{PAD_W{1'b0}}, addr[ALIAS_BITS-1:BIT_W+2], 2'b00})
      : '0;
  end

  always_comb begin
    wordAddr = '0;
    for (int i = 0; i < NUM_REGIONS; i++) wordAddr = wordAddr | regAddr[i];
  end

  assign hit    = |regHit;
  assign bitPos = addr[BIT_W+1:2];
endmodule

// File: rtl/bbx_datapath.sv
module bbx_datapath
  import bbx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic              upWrite,
  input  logic [DATA_W-1:0] upWdata,
  input  logic [STRB_W-1:0] upStrb,
  input  logic [DATA_W-1:0] dnRdata,
  output logic              aliasHit,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  output logic [STRB_W-1:0] dnStrb,
  output logic [DATA_W-1:0] upRdata
);
  logic [ADDR_W-1:0] decAddr;
  logic [BIT_W-1:0]  decBit;

  logic [ADDR_W-1:0] reqAddr, tgtAddr;
  logic [DATA_W-1:0] reqWdata, readWord, modWord, rspData;
  logic [STRB_W-1:0] reqStrb;
  logic              reqWrite;
  logic [BIT_W-1:0]  bitPos;

  bbx_alias_decode #(
    .ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)
  ) u_decode (
    .addr(upAddr), .hit(aliasHit), .wordAddr(decAddr), .bitPos(decBit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqStrb  <= '0;
      reqWrite <= 1'b0;
      tgtAddr  <= '0;
      bitPos   <= '0;
      readWord <= '0;
      modWord  <= '0;
      rspData  <= '0;
    end else begin
      if (strb.capReq) begin
        reqAddr  <= upAddr;
        reqWdata <= upWdata;
        reqStrb  <= upStrb;
        reqWrite <= upWrite;
        tgtAddr  <= decAddr;
        bitPos   <= decBit;
      end
      if (strb.capWord) begin
        readWord        <= dnRdata;
        modWord         <= dnRdata;
        modWord[bitPos] <= reqWdata[0];
      end
      if (strb.capRsp) begin
        case (strb.rspSel)
          RSP_RAW: rspData <= dnRdata;
          RSP_BIT: rspData <= {{(DATA_W-1){1'b0}}, dnRdata[bitPos]};
          default: rspData <= '0;
        endcase
      end
    end
  end

  always_comb begin
    case (strb.phase)
      PH_PASS: begin
        dnAddr  = reqAddr;
        dnWrite = reqWrite;
        dnWdata = reqWdata;
        dnStrb  = reqStrb;
      end
      PH_ALRD: begin
        dnAddr  = tgtAddr;
        dnWrite = 1'b0;
        dnWdata = '0;
        dnStrb  = '0;
      end
      default: begin
        dnAddr  = tgtAddr;
        dnWrite = 1'b1;
        dnWdata = modWord;
        dnStrb  = '1;
      end
    endcase
  end

  assign upRdata = rspData;

  // R3
  rmw_onebit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.phase == PH_ALWR) |-> ($countones(modWord ^ readWord) <= 1));

  // R2
  bit_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capRsp && strb.rspSel == RSP_BIT) |=> (upRdata[DATA_W-1:1] == '0));
endmodule

// File: rtl/bbx_ctrl.sv
module bbx_ctrl
  import bbx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      upValid,
  input  logic      upWrite,
  input  logic      aliasHit,
  input  logic      dnReady,
  input  logic      dnRspValid,
  output logic      upReady,
  output logic      upRspValid,
  output logic      dnValid,
  output logic      dnLock,
  output dpStrobe_t strb
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_PREQ, ST_PWAIT, ST_RREQ, ST_RWAIT, ST_WREQ, ST_WWAIT, ST_RESP
  } state_e;

  state_e state, stateNxt;
  logic   aliasWr, aliasWrNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      aliasWr <= 1'b0;
    end else begin
      state   <= stateNxt;
      aliasWr <= aliasWrNxt;
    end
  end

  always_comb begin
    stateNxt    = state;
    aliasWrNxt  = aliasWr;
    upReady     = 1'b0;
    upRspValid  = 1'b0;
    dnValid     = 1'b0;
    strb        = '{capReq: 1'b0, capWord: 1'b0, capRsp: 1'b0,
                    rspSel: RSP_RAW, phase: PH_PASS};
    case (state)
      ST_IDLE: begin
        upReady = 1'b1;
        if (upValid) begin
          strb.capReq = 1'b1;
          aliasWrNxt  = aliasHit && upWrite;
          stateNxt    = aliasHit ? ST_RREQ : ST_PREQ;
        end
      end
      ST_PREQ: begin
        dnValid = 1'b1;
        if (dnReady) stateNxt = ST_PWAIT;
      end
      ST_PWAIT: begin
        if (dnRspValid) begin
          strb.capRsp = 1'b1;
          stateNxt    = ST_RESP;
        end
      end
      ST_RREQ: begin
        strb.phase = PH_ALRD;
        dnValid    = 1'b1;
        if (dnReady) stateNxt = ST_RWAIT;
      end
      ST_RWAIT: begin
        strb.phase = PH_ALRD;
        if (dnRspValid) begin
          strb.capWord = 1'b1;
          if (aliasWr) begin
            stateNxt = ST_WREQ;
          end else begin
            strb.capRsp = 1'b1;
            strb.rspSel = RSP_BIT;
            stateNxt    = ST_RESP;
          end
        end
      end
      ST_WREQ: begin
        strb.phase = PH_ALWR;
        dnValid    = 1'b1;
        if (dnReady) stateNxt = ST_WWAIT;
      end
      ST_WWAIT: begin
        strb.phase = PH_ALWR;
        if (dnRspValid) begin
          strb.capRsp = 1'b1;
          strb.rspSel = RSP_ZERO;
          stateNxt    = ST_RESP;
        end
      end
      default: begin
        upRspValid = 1'b1;
        stateNxt   = ST_IDLE;
      end
    endcase
  end

  assign dnLock = aliasWr &&
    (state == ST_RREQ || state == ST_RWAIT || state == ST_WREQ || state == ST_WWAIT);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && upReady) |=> !upReady);

  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    upRspValid |=> !upRspValid);

  // R4
  lock_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dnLock) |-> dnValid);

  // R4
  lock_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dnLock) |-> $past(dnRspValid));
endmodule

// File: rtl/bitband_xlate.sv
module bitband_xlate
  import bbx_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int REGION_BITS = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upValid,
  output logic              upReady,
  input  logic [ADDR_W-1:0] upAddr,
  input  logic              upWrite,
  input  logic [DATA_W-1:0] upWdata,
  input  logic [STRB_W-1:0] upStrb,
  output logic              upRspValid,
  output logic [DATA_W-1:0] upRdata,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  output logic [STRB_W-1:0] dnStrb,
  output logic              dnLock,
  input  logic              dnRspValid,
  input  logic [DATA_W-1:0] dnRdata
);
  dpStrobe_t strb;
  logic      aliasHit;

  bbx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .upValid(upValid), .upWrite(upWrite),
    .aliasHit(aliasHit), .dnReady(dnReady), .dnRspValid(dnRspValid),
    .upReady(upReady), .upRspValid(upRspValid), .dnValid(dnValid),
    .dnLock(dnLock), .strb(strb)
  );

  bbx_datapath #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .upAddr(upAddr), .upWrite(upWrite),
    .upWdata(upWdata), .upStrb(upStrb), .dnRdata(dnRdata), .aliasHit(aliasHit),
    .dnAddr(dnAddr), .dnWrite(dnWrite), .dnWdata(dnWdata), .dnStrb(dnStrb),
    .upRdata(upRdata)
  );

  // R8
  dn_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dnValid && !dnReady) |=> (dnValid && $stable(dnAddr) && $stable(dnWrite) && $stable(dnWdata)));
endmodule

// File: tb/sim_bitband_xlate.sv
`timescale 1ns/1ps
module sim_bitband_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        upValid = 1'b0, upWrite = 1'b0;
  logic [31:0] upAddr = '0, upWdata = '0;
  logic [3:0]  upStrb = '0;
  logic        upReady, upRspValid, dnValid, dnWrite, dnLock, dnReady;
  logic [31:0] upRdata, dnAddr, dnWdata;
  logic [3:0]  dnStrb;
  logic        dnRspValid = 1'b0;
  logic [31:0] dnRdata = '0;

  int checks = 0, fails = 0;
  int stall = 0, waitCnt = 0;

  typedef struct { logic [31:0] a; logic w; logic [31:0] d; logic [3:0] s; logic l; } xfer_t;
  xfer_t dnLog[$];
  logic [31:0] physMem[logic [31:0]];
  logic [31:0] refMem[logic [31:0]];

  always #2 clk = ~clk;

  bitband_xlate u0 (
    .clk(clk), .rstN(rstN), .upValid(upValid), .upReady(upReady), .upAddr(upAddr),
    .upWrite(upWrite), .upWdata(upWdata), .upStrb(upStrb), .upRspValid(upRspValid),
    .upRdata(upRdata), .dnValid(dnValid), .dnReady(dnReady), .dnAddr(dnAddr),
    .dnWrite(dnWrite), .dnWdata(dnWdata), .dnStrb(dnStrb), .dnLock(dnLock),
    .dnRspValid(dnRspValid), .dnRdata(dnRdata)
  );

  function automatic logic [31:0] seedOf(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h3C5A_0F96;
  endfunction

  function automatic logic [31:0] physRd(input logic [31:0] a);
    return physMem.exists(a) ? physMem[a] : seedOf(a);
  endfunction

  function automatic logic [31:0] refRd(input logic [31:0] a);
    return refMem.exists(a) ? refMem[a] : seedOf(a);
  endfunction

  function automatic logic [31:0] mergeStrb(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] s);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (s[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // downstream responder: waits `stall` cycles, answers one edge after the handshake
  assign dnReady = (waitCnt >= stall);
  always @(posedge clk) begin
    dnRspValid <= 1'b0;
    if (dnValid && !dnReady) waitCnt <= waitCnt + 1;
    if (dnValid && dnReady) begin
      waitCnt <= 0;
      dnLog.push_back('{a: dnAddr, w: dnWrite, d: dnWdata, s: dnStrb, l: dnLock});
      dnRspValid <= 1'b1;
      if (dnWrite) begin
        physMem[dnAddr] = mergeStrb(physRd(dnAddr), dnWdata, dnStrb);
        dnRdata <= 32'hDEAD_BEEF;
      end else begin
        dnRdata <= physRd(dnAddr);
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // one upstream transaction with its whole expected effect computed from the requirements
  task automatic txn(input logic [31:0] a, input logic w, input logic [31:0] wd, input logic [3:0] st, input string req);
    logic        isAl;
    logic [31:0] base, tgt, expData, word;
    int          bitN, lat, expLat;
    logic        sawReady;
    xfer_t       e;
    isAl = 1'b0; base = '0;
    if (a >= 32'h2200_0000 && a <= 32'h23FF_FFFF) begin isAl = 1'b1; base = 32'h2000_0000; end
    if (a >= 32'h4200_0000 && a <= 32'h43FF_FFFF) begin isAl = 1'b1; base = 32'h4000_0000; end
    tgt  = base + ((((a - (base + 32'h0200_0000)) >> 5)) & ~32'h3);
    bitN = int'(((a - (base + 32'h0200_0000)) >> 5) & 3) * 8 + int'((a >> 2) & 7);
    if (!isAl) begin
      expLat  = 2 + stall;
      expData = w ? 32'hDEAD_BEEF : refRd(a);
      if (w) refMem[a] = mergeStrb(refRd(a), wd, st);
    end else if (!w) begin
      expLat  = 2 + stall;
      word    = refRd(tgt);
      expData = {31'b0, word[bitN]};
    end else begin
      expLat  = 4 + 2 * stall;
      expData = '0;
      word    = refRd(tgt);
      word[bitN] = wd[0];
    end
    dnLog.delete();
    upValid = 1'b1; upAddr = a; upWrite = w; upWdata = wd; upStrb = st;
    @(posedge clk); #1;
    upValid = 1'b0;
    lat = 0; sawReady = 1'b0;
    while (lat < 200) begin
      @(posedge clk); #1; lat++;
      if (upRspValid) break;
      if (upReady) sawReady = 1'b1;
    end
    chk("R7", {req, " upReady while busy"}, sawReady, 1'b0);
    chk("R6", {req, " latency"}, lat, expLat);
    chk(req, "response data", upRdata, expData);
    if (!isAl) begin
      chk("R5", {req, " transfer count"}, dnLog.size(), 1);
      if (dnLog.size() == 1) begin
        e = dnLog[0];
        chk("R5", {req, " fwd addr"}, e.a, a);
        chk("R5", {req, " fwd write"}, e.w, w);
        chk("R5", {req, " fwd data"}, e.d, wd);
        chk("R5", {req, " fwd strb"}, e.s, st);
        chk("R5", {req, " fwd lock"}, e.l, 1'b0);
      end
    end else if (!w) begin
      chk("R2", {req, " transfer count"}, dnLog.size(), 1);
      if (dnLog.size() == 1) begin
        chk("R1", {req, " target addr"}, dnLog[0].a, tgt);
        chk("R2", {req, " is read"}, dnLog[0].w, 1'b0);
        chk("R2", {req, " lock low"}, dnLog[0].l, 1'b0);
      end
    end else begin
      chk("R3", {req, " transfer count"}, dnLog.size(), 2);
      if (dnLog.size() == 2) begin
        chk("R1", {req, " read addr"}, dnLog[0].a, tgt);
        chk("R3", {req, " first is read"}, dnLog[0].w, 1'b0);
        chk("R4", {req, " read locked"}, dnLog[0].l, 1'b1);
        chk("R3", {req, " write addr"}, dnLog[1].a, tgt);
        chk("R3", {req, " second is write"}, dnLog[1].w, 1'b1);
        chk("R3", {req, " write data"}, dnLog[1].d, word);
        chk("R3", {req, " write strb"}, dnLog[1].s, 4'hF);
        chk("R4", {req, " write locked"}, dnLog[1].l, 1'b1);
      end
      refMem[tgt] = word;
    end
    @(posedge clk); #1;
    chk("R10", {req, " rsp pulse ends"}, upRspValid, 1'b0);
    chk("R4", {req, " lock idle"}, dnLog.size() > 0 ? dnLock : 1'b0, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9", "reset upReady", upReady, 1'b1);
    chk("R9", "reset dnValid", dnValid, 1'b0);
    chk("R9", "reset dnLock", dnLock, 1'b0);
    chk("R9", "reset upRspValid", upRspValid, 1'b0);
    rstN = 1'b1;
    @(posedge clk); #1;
    chk("R9", "idle upReady", upReady, 1'b1);

    txn(32'h1000_0040, 1'b0, '0, 4'h0, "R5 pass read");
    txn(32'h2000_0010, 1'b1, 32'h1234_5678, 4'b0101, "R5 pass write");
    txn(32'h2200_0000 + 32'h11 * 32 + 3 * 4, 1'b0, '0, 4'h0, "R2 sram alias read");
    txn(32'h2200_0000 + 32'h11 * 32 + 3 * 4, 1'b1, 32'h1, 4'hF, "R3 sram alias set");
    txn(32'h2000_0010, 1'b0, '0, 4'h0, "R3 readback after set");
    txn(32'h43FF_FFFC, 1'b1, 32'hFFFF_FFFE, 4'h0, "R3 periph top clear");
    txn(32'h400F_FFFC, 1'b0, '0, 4'h0, "R3 readback after clear");
    txn(32'h43FF_FFFF, 1'b0, '0, 4'h0, "R1 low bits ignored");
    txn(32'h4200_0004, 1'b1, 32'h1, 4'h1, "R1 periph base set");
    txn(32'h4200_0004, 1'b0, '0, 4'h0, "R1 periph alias readback");
    txn(32'h2400_0000, 1'b0, '0, 4'h0, "R1 above window passes");
    txn(32'h21FF_FFFC, 1'b1, 32'hA5A5_5A5A, 4'b1111, "R1 below window passes");
    stall = 2;
    txn(32'h2200_1234, 1'b1, 32'h0, 4'hF, "R6 stalled alias write");
    txn(32'h2200_1234, 1'b0, '0, 4'h0, "R6 stalled alias read");
    txn(32'h3000_0100, 1'b0, '0, 4'h0, "R8 stalled pass read");
    stall = 0;
    txn(32'h2000_0000 + ((32'h1234 - 32'h0) >> 5 & ~32'h3), 1'b0, '0, 4'h0, "R3 readback after stall");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule